// File: doc/BRIEF.md
# Late-Capture SPI Master

This block is a serial peripheral master meant for fast memory-style slaves. A host hands it a byte and a start pulse. The master pulls its active-low select low, toggles the serial clock and shifts the byte out most significant bit first. It returns the byte shifted in from the slave. Several bytes can be chained in one selection window: the host flags that another byte follows, and the master fetches it at the byte boundary without stopping the clock.

The serial clock idles low. Outgoing bits change on falling clock edges, so the slave samples them on rising edges. The slave launches each return bit on a falling edge, and the master samples the return line on the next falling edge, not on the rising edge in between. The whole loop through the slave (clock out, slave access, data back) therefore has one full clock period rather than half of one, which allows about twice the clock rate. The timing is not any of the four usual clock modes.

The serial clock is made from the system clock by a programmable even divide. Each clock edge is an enable strobe inside the system clock domain. All outputs come straight from flops.

Top module: `spi_late_capture_master`

## Requirements
- R1: A synchronous active-high reset, applied at any time, forces `cs_n`=1, `sck`=0, `mosi`=0, `busy`=0, `tx_load`=0, `byte_done`=0 and `rx_byte`=0 after the next clock edge.
- R2: `sck` is low whenever `cs_n` is high. While `cs_n` is low, every high and low level of `sck` lasts exactly H system cycles, where H is `half_div` and a value of 0 counts as 1. Each byte gives exactly 8 rising edges.
- R3: A `start` pulse seen while idle drives `cs_n` low and `busy` high on the next clock edge. From that same edge `mosi` carries bit 7 of `tx_byte`. The first rising edge of `sck` comes H cycles after `cs_n` falls.
- R4: While `cs_n` stays low, `mosi` changes only together with a falling edge of `sck`. Bits leave most significant first (bit 7, then 6, down to 0), so the slave, sampling on rising edges, receives each byte unchanged.
- R5: `miso` is sampled at falling edges of `sck`. Return bit k (k=0 is the most significant) is taken at falling edge k+1, so the byte completes on the 8th falling edge with no extra clock. `rx_byte` is updated, most significant bit first, and `byte_done` pulses for one cycle on that same edge.
- R6: `tx_byte` and `tx_more` are latched at the start and at every byte boundary whose latched `tx_more` was 1. `tx_load` pulses for one cycle per latch. Chained bytes follow with no idle clock periods, so an N-byte window keeps `cs_n` low for exactly (16N+1)·H cycles.
- R7: `cs_n` rises H cycles after the final falling edge, with `sck` low. At that edge `busy` drops and `mosi` returns to 0. `busy` is high exactly while `cs_n` is low.
- R8: A `start` pulse while `busy` is high is ignored. The running window keeps its length, its byte count and its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to open a window, taken only when idle |
| tx_byte | input | W | Byte to transmit, latched at start and at chained byte boundaries |
| tx_more | input | 1 | Latched with `tx_byte`; 1 means another byte follows |
| half_div | input | DIV_W | Serial clock half period in system cycles (0 treated as 1) |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low slave select |
| busy | output | 1 | High while a window is open |
| tx_load | output | 1 | Pulses when `tx_byte`/`tx_more` were just latched |
| byte_done | output | 1 | Pulses when `rx_byte` holds a fresh byte |
| rx_byte | output | W | Last received byte |

## Verification
Windows of one, two and three bytes are run at half periods of 0, 1, 2, 3, 4 and 8. The slave returns data through a delay just under a full clock period. With that delay a falling-edge capture reads the right bit, while a rising-edge capture reads the previous bit. Data patterns of all zeros, all ones, a lone set bit at each end and alternating bits separate a bit-order fault from a shift-by-one fault. Exact window lengths and level-run lengths expose idle gaps between chained bytes. A stray start inside a window, and a reset in mid-byte, check that the control state can be neither disturbed nor left stuck.

// File: rtl/slcm_pkg.sv
package slcm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_TAIL = 2'd3
  } phase_t;
endpackage

// File: rtl/slcm_tick_gen.sv
module slcm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // a zero divider behaves as one system cycle per level
  always_comb lim = (half_div == '0) ? '0 : half_div - 1'b1;
  always_comb tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/slcm_shifter.sv
module slcm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic         capture,
  input  logic         clear,
  input  logic [W-1:0] din,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_next
);
  logic [W-1:0] tx_sr;
  logic [W-2:0] rx_sr;

  always_ff @(posedge clk) begin
    if (rst || clear) tx_sr <= '0;
    else if (load)    tx_sr <= din;
    else if (shift)   tx_sr <= {tx_sr[W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)          rx_sr <= '0;
    else if (capture) rx_sr <= rx_next[W-2:0];
  end

  assign mosi    = tx_sr[W-1];
  assign rx_next = {rx_sr, miso};
endmodule

// File: rtl/slcm_ctrl.sv
module slcm_ctrl
  import slcm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tx_more,
  input  logic tick,
  output logic run,
  output logic load,
  output logic shift,
  output logic capture,
  output logic clear,
  output logic last_bit,
  output logic sck,
  output logic cs_n,
  output logic busy,
  output logic tx_load,
  output logic byte_done
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] bcnt;
  logic             more_q;
  logic             launch;
  logic             fall;

  always_comb begin
    run      = (phase_q != PH_IDLE);
    launch   = (phase_q == PH_IDLE) && start;
    fall     = (phase_q == PH_HIGH) && tick;
    last_bit = fall && (bcnt == LAST);
    load     = launch || (last_bit && more_q);
    shift    = fall && !load;
    capture  = fall;
    clear    = (phase_q == PH_TAIL) && tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      bcnt      <= '0;
      more_q    <= 1'b0;
      sck       <= 1'b0;
      cs_n      <= 1'b1;
      busy      <= 1'b0;
      tx_load   <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      tx_load   <= load;
      byte_done <= last_bit;
      if (load) more_q <= tx_more;
      case (phase_q)
        PH_IDLE: if (launch) begin
          phase_q <= PH_LOW;
          cs_n    <= 1'b0;
          busy    <= 1'b1;
          bcnt    <= '0;
        end
        PH_LOW: if (tick) begin
          phase_q <= PH_HIGH;
          sck     <= 1'b1;
        end
        PH_HIGH: if (tick) begin
          sck     <= 1'b0;
          bcnt    <= last_bit ? '0 : bcnt + 1'b1;
          phase_q <= (last_bit && !more_q) ? PH_TAIL : PH_LOW;
        end
        PH_TAIL: if (tick) begin
          phase_q <= PH_IDLE;
          cs_n    <= 1'b1;
          busy    <= 1'b0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_late_capture_master.sv
module spi_late_capture_master #(
  parameter int W     = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     tx_byte,
  input  logic             tx_more,
  input  logic [DIV_W-1:0] half_div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic             busy,
  output logic             tx_load,
  output logic             byte_done,
  output logic [W-1:0]     rx_byte
);
  logic         run, tick;
  logic         load, shift, capture, clear, last_bit;
  logic [W-1:0] rx_next;

  slcm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .half_div(half_div), .tick(tick)
  );

  slcm_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .tx_more(tx_more), .tick(tick),
    .run(run), .load(load), .shift(shift), .capture(capture), .clear(clear),
    .last_bit(last_bit), .sck(sck), .cs_n(cs_n), .busy(busy),
    .tx_load(tx_load), .byte_done(byte_done)
  );

  slcm_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .shift(shift), .capture(capture),
    .clear(clear), .din(tx_byte), .miso(miso), .mosi(mosi), .rx_next(rx_next)
  );

  always_ff @(posedge clk) begin
    if (rst)           rx_byte <= '0;
    else if (last_bit) rx_byte <= rx_next;
  end
endmodule

// File: rtl/slcm_checker.sv
module slcm_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             tx_msb,
  input logic [DIV_W-1:0] half_div,
  input logic             sck,
  input logic             mosi,
  input logic             cs_n,
  input logic             busy,
  input logic             tx_load,
  input logic             byte_done
);
  logic             sck_d, cs_d, mosi_d;
  logic [DIV_W:0]   q;
  logic [DIV_W:0]   h_eff;

  assign h_eff = (half_div == '0) ? (DIV_W+1)'(1) : {1'b0, half_div};

  // q: number of samples the previous (sck, cs_n) pair was held
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      mosi_d <= 1'b0;
      q      <= (DIV_W+1)'(1);
    end else begin
      sck_d  <= sck;
      cs_d   <= cs_n;
      mosi_d <= mosi;
      if (sck != sck_d || cs_n != cs_d) q <= (DIV_W+1)'(1);
      else if (q != '1)                 q <= q + 1'b1;
    end
  end

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  assert_half_period_R2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !cs_d && sck != sck_d) |-> (q == h_eff));

  assert_open_R3: assert property (@(posedge clk) disable iff (rst)
    (cs_d && !cs_n) |-> ($past(start) && busy && mosi == $past(tx_msb)));

  assert_mosi_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !cs_d && mosi != mosi_d) |-> (sck_d && !sck));

  assert_done_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> (sck_d && !sck && !cs_n));

  assert_load_point_R6: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> ((cs_d && !cs_n) || (sck_d && !sck)));

  assert_close_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !cs_d) |-> (q == h_eff && !sck && !busy && !mosi));

  assert_busy_window_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cs_n);
endmodule

bind spi_late_capture_master slcm_checker #(.DIV_W(DIV_W)) i_chk (
  .clk(clk), .rst(rst), .start(start), .tx_msb(tx_byte[W-1]),
  .half_div(half_div), .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy),
  .tx_load(tx_load), .byte_done(byte_done)
);

// File: tb/test_spi_late_capture_master.sv
module test_spi_late_capture_master;
  localparam int W = 8, DIV_W = 8, MAXB = 3, NV = 6;

  logic             clk = 1'b0, rst = 1'b1, start = 1'b0, tx_more = 1'b0;
  logic [W-1:0]     tx_byte = '0;
  logic [DIV_W-1:0] half_div = 8'd2;
  logic             miso;
  logic             sck, mosi, cs_n, busy, tx_load, byte_done;
  logic [W-1:0]     rx_byte;

  int checks = 0, fails = 0;

  // {half_div, poke|nbytes, tx0, tx1, tx2, slave0, slave1, slave2}
  localparam logic [63:0] VEC [NV] = '{
    {8'd2, 8'h01, 8'hA5, 8'h00, 8'h00, 8'hC3, 8'h00, 8'h00},
    {8'd1, 8'h02, 8'h3C, 8'h81, 8'h00, 8'h5A, 8'hE7, 8'h00},
    {8'd3, 8'h03, 8'h00, 8'hFF, 8'h96, 8'hFF, 8'h00, 8'h69},
    {8'd0, 8'h01, 8'h80, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00},
    {8'd4, 8'h82, 8'h01, 8'h7E, 8'h00, 8'h80, 8'h24, 8'h00},
    {8'd8, 8'h01, 8'h6D, 8'h00, 8'h00, 8'hB2, 8'h00, 8'h00}
  };

  always #10 clk = ~clk;

  spi_late_capture_master #(.W(W), .DIV_W(DIV_W)) i_spi_late_capture_master (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte), .tx_more(tx_more),
    .half_div(half_div), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .tx_load(tx_load), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  // ---------------- slave model ----------------
  logic [W*MAXB-1:0] sl_stream = '0;
  logic [W*MAXB-1:0] sl_rx = '0;
  int cs_gen = 0, fall_gen = 0, falls = 0, rx_gen = 0;
  logic sl_raw;
  logic [15:0] dly = '0;
  int dsel = 1;

  always @(negedge cs_n) cs_gen = cs_gen + 1;

  always @(negedge sck) begin
    if (fall_gen != cs_gen) begin fall_gen = cs_gen; falls = 1; end
    else falls = falls + 1;
  end

  always @(posedge sck) begin
    if (rx_gen != cs_gen) begin rx_gen = cs_gen; sl_rx = '0; end
    sl_rx = {sl_rx[W*MAXB-2:0], mosi};
  end

  // bit k launched at select fall (k=0) or at falling edge k
  always @* begin
    int b;
    b = (fall_gen != cs_gen) ? 0 : falls;
    sl_raw = (b < W*MAXB) ? sl_stream[W*MAXB-1-b] : 1'b0;
  end

  // return path delayed by 2H-1 system cycles
  always @(posedge clk) dly <= {dly[14:0], sl_raw};
  assign miso = dly[dsel-1];

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_window(input int h, input int n, input logic [W-1:0] t0, t1, t2,
                            input logic [W-1:0] s0, s1, s2, input bit poke);
    logic [W-1:0] tx [MAXB];
    logic [W-1:0] sx [MAXB];
    logic [W*MAXB-1:0] exp_rx;
    logic [W*MAXB-1:0] mask;
    int he, loads, done, cyc, rises, runlen, runbad;
    logic prev_sck;
    tx[0] = t0; tx[1] = t1; tx[2] = t2;
    sx[0] = s0; sx[1] = s1; sx[2] = s2;
    he = (h == 0) ? 1 : h;
    @(negedge clk);
    half_div  = DIV_W'(h);
    sl_stream = {s0, s1, s2};
    dsel      = 2*he - 1;
    tx_byte   = t0;
    tx_more   = (n > 1);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 cs_n falls after start", cs_n, 0);
    chk("R3 busy rises after start", busy, 1);
    chk("R3 mosi carries bit 7", mosi, t0[W-1]);
    chk("R2 sck low at open", sck, 0);
    loads = 0; done = 0; cyc = 0; rises = 0; runlen = 0; runbad = 0; prev_sck = 1'b0;
    while (!cs_n && cyc < 5000) begin
      cyc++;
      if (sck != prev_sck) begin
        if (runlen != he) runbad++;
        runlen = 1;
        if (sck) rises++;
        prev_sck = sck;
      end else runlen++;
      if (tx_load) begin
        loads++;
        if (loads < n) begin tx_byte = tx[loads]; tx_more = (loads < n-1); end
      end
      if (byte_done) begin
        if (done < MAXB) chk("R5 rx_byte at 8th falling edge", rx_byte, sx[done]);
        done++;
      end
      chk("R7 busy while cs_n low", busy, 1);
      if (poke && cyc == 5) start = 1'b1;
      if (poke && cyc == 6) start = 1'b0;
      @(negedge clk);
    end
    chk("R7 final low level lasts H", runlen, he);
    chk("R2 level runs equal H", runbad, 0);
    chk("R2 eight rises per byte", rises, W*n);
    chk("R6 window length (16N+1)H", cyc, (2*W*n+1)*he);
    chk("R6 one tx_load per byte", loads, n);
    chk("R5 byte_done count", done, n);
    chk("R7 busy low after close", busy, 0);
    chk("R7 mosi zero after close", mosi, 0);
    chk("R2 sck low after close", sck, 0);
    exp_rx = '0;
    for (int i = 0; i < n; i++) exp_rx = (exp_rx << W) | {{(W*(MAXB-1)){1'b0}}, tx[i]};
    mask = (n >= MAXB) ? '1 : (({{(W*MAXB-1){1'b0}}, 1'b1} << (W*n)) - 1'b1);
    chk(poke ? "R8 data intact after stray start" : "R4 slave received bytes",
        32'(sl_rx & mask), 32'(exp_rx));
    if (poke) chk("R8 stray start added no byte", done, n);
    repeat (3) @(negedge clk);
    chk("R8 no reopen after window", cs_n, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset cs_n", cs_n, 1);
    chk("R1 reset sck", sck, 0);
    chk("R1 reset mosi", mosi, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset tx_load", tx_load, 0);
    chk("R1 reset byte_done", byte_done, 0);
    chk("R1 reset rx_byte", rx_byte, 0);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      v = VEC[i];
      run_window(int'(v[63:56]), int'(v[51:48]), v[47:40], v[39:32], v[31:24],
                 v[23:16], v[15:8], v[7:0], v[55]);
    end

    // reset in mid-byte
    @(negedge clk);
    half_div = 8'd2; dsel = 3; tx_byte = 8'hF0; tx_more = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (11) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-transfer reset cs_n", cs_n, 1);
    chk("R1 mid-transfer reset sck", sck, 0);
    chk("R1 mid-transfer reset busy", busy, 0);
    chk("R1 mid-transfer reset mosi", mosi, 0);
    repeat (20) @(negedge clk);

    // recovery after reset
    run_window(2, 1, 8'h5B, 8'h00, 8'h00, 8'h3E, 8'h00, 8'h00, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule